// File: doc/BRIEF.md
# Display Capability Read Engine (I2C, windowed)

This block is a small I2C master that fetches a display sink's capability table over the display data channel. Software programs a command word with a byte count, a transaction type and a start bit. The engine then runs the bus sequence itself: START, device address 0x50 with the write direction, word offset 0, repeated START, device address 0x50 with the read direction, and then the data bytes. Received bytes are packed into a 16-word receive window.

The window holds 64 bytes. When it fills and bytes are still outstanding, the engine raises a window-full status bit, holds SCL low and waits. Software drains the window, clears the bit and writes the continue bit. The next byte then lands at the start of the window again. After the final byte the engine sends a NACK, then a STOP, and raises a transfer-complete status bit. If the sink fails to acknowledge a byte sent by the master, the engine raises an error bit and ends with a STOP instead.

Status bits are cleared by writing one to them. A single interrupt line combines the status bits with an enable mask. The SCL rate comes from a programmable clock divider.

Top module: `ddc_read_engine`

## Requirements
- R1: After reset, the command, enable and status registers read 0, the divider register reads its reset value (124 by default), `irq` is 0, and whenever the engine is idle both `scl_out` and `sda_out` are 1 (released).
- R2: The command register is at word address 0. It has the byte count in bits [31:20], the type in bits [3:2] (3 means capability read), a start bit at bit 0 and a continue bit at bit 1. The continue bit always reads back as 0. A write with bit 0 set while idle, type 3 and a nonzero count starts the bus sequence to device 0x50 from offset 0.
- R3: Byte k of a window (0 to 63) is read at word address 16 + k/4, in bits [8*(k%4)+7 : 8*(k%4)]. The first byte of the window goes to the least significant byte of word 16.
- R4: After the 64th byte of a window, if more bytes remain, status bit 3 is set and SCL stays low with no further progress until a command write with bit 1 set. The following byte is stored at word 16, lane 0.
- R5: After the last requested byte, status bit 2 is set, following a NACK and a STOP. When the last byte also fills the window, only bit 2 is raised and bit 3 is not.
- R6: A missing acknowledge from the sink sets status bit 4, ends the transfer with a STOP, and does not set bit 2.
- R7: A start request with a type other than 3 sets status bit 4 at once. A start request with type 3 and count 0 sets bit 2 at once. Neither request causes any bus activity.
- R8: The status register is at word address 2. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: The enable register is at word address 1, with bits 4, 3, 2 and 0. `irq` is 1 exactly when a status bit and its enable bit are both 1, so an all-zero enable keeps `irq` at 0.
- R10: A one-cycle pulse on `hpd_evt` sets status bit 0.
- R11: The divider register is at word address 3. Each quarter of an SCL bit lasts divider+1 clock cycles, so a data-bit SCL high phase lasts 2*(divider+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| hpd_evt | input | 1 | Hot-plug event pulse, sets status bit 0 |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_out | output | 1 | SCL drive, 0 pulls the line low, 1 releases it |
| sda_out | output | 1 | SDA drive, 0 pulls the line low, 1 releases it |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest state to reach from the ports is the window stall, where SCL is held low mid-transfer while software inspects the buffer. It needs a responsive sink that acknowledges the address and offset, follows the repeated START and streams a known byte pattern through several complete windows. The bench therefore contains a behavioural sink that serves a computed byte sequence. It runs byte counts that end below a window, exactly on a window boundary and past one or two boundaries. The missing-acknowledge path is reached by telling that sink to ignore its address for one transfer.

// File: rtl/ddc_pkg.sv
// Shared constants and types for the windowed capability read engine.
// Assumes a 32-bit register data path and word addressing.
package ddc_pkg;
    // register word addresses
    localparam int REG_CMD  = 0;
    localparam int REG_IEN  = 1;
    localparam int REG_STAT = 2;
    localparam int REG_DIV  = 3;

    // command word fields
    localparam int CMD_GO       = 0;
    localparam int CMD_CONT     = 1;
    localparam int CMD_TYPE_LSB = 2;
    localparam int CMD_CNT_LSB  = 20;

    // status / enable bit positions
    localparam int ST_HPD  = 0;
    localparam int ST_DONE = 2;
    localparam int ST_FULL = 3;
    localparam int ST_ERR  = 4;
    localparam logic [4:0] STAT_MASK = 5'b11101;

    localparam logic [1:0] TYPE_CAP_READ = 2'd3;
    localparam logic [6:0] SINK_ADDR     = 7'h50;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_WBYTE,
        SQ_RBYTE,
        SQ_HOLD,
        SQ_STOP
    } seq_state_t;
endpackage

// File: rtl/ddc_tick_gen.sv
// Quarter-bit timebase: emits one tick every div+1 clocks while run is high.
// Assumes div is stable during a transfer; the counter restarts when idle.
module ddc_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // count clocks up to the divider value, restart while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ddc_rx_buffer.sv
// Receive window: WORDS words of 32 bits, written one byte at a time.
// Byte position p goes to word p/4, lane p%4 (lane 0 = least significant).
module ddc_rx_buffer #(
    parameter int WORDS = 16,
    localparam int POS_W  = $clog2(WORDS * 4),
    localparam int WIDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [POS_W-1:0]  wr_pos,
    input  logic [7:0]        wr_byte,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [31:0]       rd_word
);
    logic [WORDS-1:0][31:0] words;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [31:0] word_q;

        // store an incoming byte into its lane when this word is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && (wr_pos[POS_W-1:2] == WIDX_W'(w))) begin
                for (int l = 0; l < 4; l++) begin
                    if (wr_pos[1:0] == 2'(l)) begin
                        word_q[8*l +: 8] <= wr_byte;
                    end
                end
            end
        end

        assign words[w] = word_q;
    end

    assign rd_word = words[rd_idx];
endmodule

// File: rtl/ddc_seq.sv
// Bus sequencer: START, address+W, offset 0, repeated START, address+R,
// then COUNT data bytes with ACK, NACK on the last one, STOP.
// Each bit spans four ticks: set SDA, raise SCL, sample, lower SCL.
// Stalls with SCL low after every full window until resume.
module ddc_seq import ddc_pkg::*; #(
    parameter int CNT_W = 12,
    parameter int POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] count,
    input  logic             resume,
    input  logic             tick,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o,
    output logic             busy,
    output logic             stalled,
    output logic             wr_en,
    output logic [POS_W-1:0] wr_pos,
    output logic [7:0]       wr_byte,
    output logic             ev_full,
    output logic             ev_done,
    output logic             ev_err
);
    localparam logic [POS_W-1:0] LAST_POS = '1;

    seq_state_t       st;
    logic [1:0]       ph;
    logic [3:0]       bitn;
    logic [7:0]       txb;
    logic [7:0]       rxb;
    logic [1:0]       wsel;
    logic [CNT_W-1:0] left;
    logic [POS_W-1:0] pos;
    logic             nack_seen;

    assign busy    = (st != SQ_IDLE);
    assign stalled = (st == SQ_HOLD);

    // main sequencing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            ph        <= '0;
            bitn      <= '0;
            txb       <= '0;
            rxb       <= '0;
            wsel      <= '0;
            left      <= '0;
            pos       <= '0;
            nack_seen <= 1'b0;
            scl_o     <= 1'b1;
            sda_o     <= 1'b1;
            wr_en     <= 1'b0;
            wr_pos    <= '0;
            wr_byte   <= '0;
            ev_full   <= 1'b0;
            ev_done   <= 1'b0;
            ev_err    <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            ev_full <= 1'b0;
            ev_done <= 1'b0;
            ev_err  <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (go) begin
                        st        <= SQ_START;
                        ph        <= '0;
                        wsel      <= '0;
                        left      <= count;
                        pos       <= '0;
                        nack_seen <= 1'b0;
                    end
                end
                SQ_START: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        case (ph)
                            2'd0: sda_o <= 1'b1;
                            2'd1: scl_o <= 1'b1;
                            2'd2: sda_o <= 1'b0;
                            default: begin
                                scl_o <= 1'b0;
                                st    <= SQ_WBYTE;
                                bitn  <= '0;
                                txb   <= {SINK_ADDR, (wsel != 2'd0)};
                            end
                        endcase
                    end
                end
                SQ_WBYTE: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        case (ph)
                            2'd0: sda_o <= (bitn == 4'd8) ? 1'b1 : txb[7];
                            2'd1: scl_o <= 1'b1;
                            2'd2: if (bitn == 4'd8) nack_seen <= sda_i;
                            default: begin
                                scl_o <= 1'b0;
                                if (bitn != 4'd8) begin
                                    txb  <= {txb[6:0], 1'b0};
                                    bitn <= bitn + 4'd1;
                                end else begin
                                    bitn <= '0;
                                    if (nack_seen) begin
                                        ev_err <= 1'b1;
                                        st     <= SQ_STOP;
                                    end else if (wsel == 2'd0) begin
                                        wsel <= 2'd1;
                                        txb  <= 8'h00;
                                    end else if (wsel == 2'd1) begin
                                        wsel <= 2'd2;
                                        st   <= SQ_START;
                                    end else begin
                                        st <= SQ_RBYTE;
                                    end
                                end
                            end
                        endcase
                    end
                end
                SQ_RBYTE: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        case (ph)
                            2'd0: sda_o <= (bitn != 4'd8) || (left == CNT_W'(1));
                            2'd1: scl_o <= 1'b1;
                            2'd2: if (bitn != 4'd8) rxb <= {rxb[6:0], sda_i};
                            default: begin
                                scl_o <= 1'b0;
                                if (bitn != 4'd8) begin
                                    bitn <= bitn + 4'd1;
                                end else begin
                                    bitn    <= '0;
                                    wr_en   <= 1'b1;
                                    wr_pos  <= pos;
                                    wr_byte <= rxb;
                                    pos     <= pos + 1'b1;
                                    left    <= left - 1'b1;
                                    if (left == CNT_W'(1)) begin
                                        st <= SQ_STOP;
                                    end else if (pos == LAST_POS) begin
                                        st      <= SQ_HOLD;
                                        ev_full <= 1'b1;
                                    end
                                end
                            end
                        endcase
                    end
                end
                SQ_HOLD: begin
                    ph <= '0;
                    if (resume) begin
                        st <= SQ_RBYTE;
                    end
                end
                SQ_STOP: begin
                    if (tick) begin
                        ph <= ph + 2'd1;
                        case (ph)
                            2'd0: sda_o <= 1'b0;
                            2'd1: scl_o <= 1'b1;
                            2'd2: sda_o <= 1'b1;
                            default: begin
                                st <= SQ_IDLE;
                                if (!nack_seen) ev_done <= 1'b1;
                            end
                        endcase
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ddc_read_engine.sv
// Top: register file (command, enable, status, divider), receive window,
// timebase and bus sequencer. Status bits clear on write-one; a new
// event in the same cycle wins over the clear. Assumes CNT_W <= 12.
module ddc_read_engine import ddc_pkg::*; #(
    parameter int CNT_W     = 12,
    parameter int DIV_W     = 16,
    parameter int DIV_INIT  = 124,
    parameter int WIN_WORDS = 16,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              hpd_evt,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic              irq
);
    localparam int WIN_BYTES = WIN_WORDS * 4;
    localparam int POS_W     = $clog2(WIN_BYTES);
    localparam int WIDX_W    = $clog2(WIN_WORDS);

    logic [CNT_W-1:0] cmd_cnt;
    logic [1:0]       cmd_type;
    logic             cmd_en;
    logic [4:0]       ien_q;
    logic [4:0]       stat_q;
    logic [DIV_W-1:0] div_q;

    logic sel_cmd, wr_cmd, wr_ien, wr_stat, wr_div, sel_buf;
    logic start_req, go_bus, imm_err, imm_done, resume;
    logic [1:0]       new_type;
    logic [CNT_W-1:0] new_cnt;
    logic [4:0]       stat_set, stat_clr;
    logic             ien_zero;

    logic             busy, stalled, tick;
    logic             wr_en, ev_full, ev_done, ev_err;
    logic [POS_W-1:0] wr_pos;
    logic [7:0]       wr_byte;
    logic [31:0]      buf_word;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata;

    // address decode and command interpretation
    assign sel_cmd  = (reg_addr == ADDR_W'(REG_CMD));
    assign wr_cmd   = reg_we && sel_cmd;
    assign wr_ien   = reg_we && (reg_addr == ADDR_W'(REG_IEN));
    assign wr_stat  = reg_we && (reg_addr == ADDR_W'(REG_STAT));
    assign wr_div   = reg_we && (reg_addr == ADDR_W'(REG_DIV));
    assign sel_buf  = (reg_addr[ADDR_W-1:WIDX_W] == (ADDR_W-WIDX_W)'(1));

    assign new_type  = reg_wdata[CMD_TYPE_LSB +: 2];
    assign new_cnt   = reg_wdata[CMD_CNT_LSB +: CNT_W];
    assign start_req = wr_cmd && reg_wdata[CMD_GO] && !busy;
    assign go_bus    = start_req && (new_type == TYPE_CAP_READ) && (new_cnt != '0);
    assign imm_err   = start_req && (new_type != TYPE_CAP_READ);
    assign imm_done  = start_req && (new_type == TYPE_CAP_READ) && (new_cnt == '0);
    assign resume    = wr_cmd && reg_wdata[CMD_CONT];
    assign ien_zero  = (ien_q == '0);

    // command register: fields latch only while idle, enable bit always
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_cnt  <= '0;
            cmd_type <= '0;
            cmd_en   <= 1'b0;
        end else if (wr_cmd) begin
            cmd_en <= reg_wdata[CMD_GO];
            if (!busy) begin
                cmd_cnt  <= new_cnt;
                cmd_type <= new_type;
            end
        end
    end

    // interrupt enable and divider registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            div_q <= DIV_W'(DIV_INIT);
        end else begin
            if (wr_ien) ien_q <= reg_wdata[4:0] & STAT_MASK;
            if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
        end
    end

    // status register: sticky events, write-one-to-clear
    always_comb begin
        stat_set          = '0;
        stat_set[ST_ERR]  = ev_err | imm_err;
        stat_set[ST_FULL] = ev_full;
        stat_set[ST_DONE] = ev_done | imm_done;
        stat_set[ST_HPD]  = hpd_evt;
        stat_clr          = wr_stat ? reg_wdata[4:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= ((stat_q & ~stat_clr) | stat_set) & STAT_MASK;
        end
    end

    assign irq = |(stat_q & ien_q);

    // register read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (sel_buf) begin
            reg_rdata = buf_word;
        end else begin
            case (reg_addr)
                ADDR_W'(REG_CMD): begin
                    reg_rdata[CMD_CNT_LSB +: CNT_W]  = cmd_cnt;
                    reg_rdata[CMD_TYPE_LSB +: 2]     = cmd_type;
                    reg_rdata[CMD_GO]                = cmd_en;
                end
                ADDR_W'(REG_IEN):  reg_rdata[4:0]       = ien_q;
                ADDR_W'(REG_STAT): reg_rdata[4:0]       = stat_q;
                ADDR_W'(REG_DIV):  reg_rdata[DIV_W-1:0] = div_q;
                default:           reg_rdata            = '0;
            endcase
        end
    end

    ddc_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (div_q),
        .tick (tick)
    );

    ddc_rx_buffer #(.WORDS(WIN_WORDS)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_pos (wr_pos),
        .wr_byte(wr_byte),
        .rd_idx (reg_addr[WIDX_W-1:0]),
        .rd_word(buf_word)
    );

    ddc_seq #(.CNT_W(CNT_W), .POS_W(POS_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go_bus),
        .count  (new_cnt),
        .resume (resume),
        .tick   (tick),
        .sda_i  (sda_in),
        .scl_o  (scl_out),
        .sda_o  (sda_out),
        .busy   (busy),
        .stalled(stalled),
        .wr_en  (wr_en),
        .wr_pos (wr_pos),
        .wr_byte(wr_byte),
        .ev_full(ev_full),
        .ev_done(ev_done),
        .ev_err (ev_err)
    );
endmodule

// File: rtl/ddc_read_engine_chk.sv
// Property checker for the windowed read engine, bound into the top.
// Observes bus drives, sequencer events and status/enable state.
module ddc_read_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_out,
    input logic sda_out,
    input logic irq,
    input logic busy,
    input logic stalled,
    input logic ev_full,
    input logic ev_done,
    input logic ev_err,
    input logic wr_stat,
    input logic w1c_done,
    input logic sel_cmd,
    input logic cont_rd,
    input logic stat_done,
    input logic ien_zero
);
    logic err_in_flight;

    // remember that the current transfer hit a missing acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_in_flight <= 1'b0;
        end else if (ev_err) begin
            err_in_flight <= 1'b1;
        end else if (!busy) begin
            err_in_flight <= 1'b0;
        end
    end

    // R1
    idle_bus_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_out && sda_out));

    // R2
    cont_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_cmd |-> !cont_rd);

    // R4
    stall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !scl_out);

    // R5
    full_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_full && ev_done));

    // R6
    err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> !err_in_flight);

    // R8
    w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && w1c_done && !ev_done) |=> !stat_done);

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_zero |-> !irq);
endmodule

bind ddc_read_engine ddc_read_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_out  (scl_out),
    .sda_out  (sda_out),
    .irq      (irq),
    .busy     (busy),
    .stalled  (stalled),
    .ev_full  (ev_full),
    .ev_done  (ev_done),
    .ev_err   (ev_err),
    .wr_stat  (wr_stat),
    .w1c_done (reg_wdata[2]),
    .sel_cmd  (sel_cmd),
    .cont_rd  (reg_rdata[1]),
    .stat_done(stat_q[2]),
    .ien_zero (ien_zero)
);

// File: tb/ddc_read_engine_test.sv
// Bench: behavioural sink at address 0x50 serving byte i = (29*i+7) mod 256,
// a vector table of transfer lengths, then directed corner-case tests.
module ddc_read_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hpd_evt = 1'b0;
    logic        scl_out, sda_out, irq;
    logic        slv_sda = 1'b1;
    wire         sda_line = sda_out & slv_sda;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddc_read_engine uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .hpd_evt  (hpd_evt),
        .sda_in   (sda_line),
        .scl_out  (scl_out),
        .sda_out  (sda_out),
        .irq      (irq)
    );

    // ---------------- behavioural sink ----------------
    int       slv_mode = 0;   // 0 idle, 1 address, 2 offset, 3 sending
    int       bitcnt = 0;
    int       ptr = 0;
    logic [7:0] sh = '0;
    logic     mack = 1'b0;
    bit       nack_addr = 1'b0;

    function automatic logic [7:0] rom(int i);
        return 8'((i * 29 + 7) & 255);
    endfunction

    always @(negedge sda_line) if (scl_out === 1'b1) begin
        slv_mode = 1; bitcnt = 0; slv_sda = 1'b1;
    end
    always @(posedge sda_line) if (scl_out === 1'b1) begin
        slv_mode = 0; slv_sda = 1'b1;
    end
    always @(posedge scl_out) begin
        if (slv_mode == 1 || slv_mode == 2) begin
            if (bitcnt < 8) sh = {sh[6:0], sda_line};
            bitcnt++;
        end else if (slv_mode == 3) begin
            if (bitcnt == 8) mack = sda_line;
            bitcnt++;
        end
    end
    always @(negedge scl_out) begin
        logic [7:0] b;
        if (slv_mode == 1 || slv_mode == 2) begin
            if (bitcnt == 8) begin
                if (slv_mode == 2 || (sh[7:1] == 7'h50 && !nack_addr)) slv_sda = 1'b0;
                else slv_mode = 0;
            end else if (bitcnt == 9) begin
                slv_sda = 1'b1; bitcnt = 0;
                if (slv_mode == 2) begin
                    ptr = int'(sh); slv_mode = 0;
                end else if (sh[0]) begin
                    slv_mode = 3; b = rom(ptr); slv_sda = b[7];
                end else begin
                    slv_mode = 2;
                end
            end
        end else if (slv_mode == 3) begin
            b = rom(ptr);
            if (bitcnt < 8) slv_sda = b[7-bitcnt];
            else if (bitcnt == 8) slv_sda = 1'b1;
            else begin
                bitcnt = 0; ptr++;
                if (mack) begin slv_mode = 0; slv_sda = 1'b1; end
                else begin b = rom(ptr); slv_sda = b[7]; end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input int max, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < max; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; break; end
        end
    endtask

    function automatic logic [31:0] cmd_word(int cnt, int typ, bit go, bit cont);
        return (32'(cnt) << 20) | (32'(typ) << 2) | (32'(cont) << 1) | 32'(go);
    endfunction

    // R3: compare window words against the sink's byte sequence
    task automatic check_window(input int base, input int nbytes, input string req);
        int bad = 0;
        logic [31:0] rd, exp, msk;
        logic [31:0] first_rd = '0, first_exp = '0;
        for (int w = 0; w < 16; w++) begin
            if (4 * w < nbytes) begin
                exp = '0; msk = '0;
                for (int l = 0; l < 4; l++) begin
                    if (4 * w + l < nbytes) begin
                        exp[8*l +: 8] = rom(base + 4 * w + l);
                        msk[8*l +: 8] = 8'hFF;
                    end
                end
                reg_read(16 + w, rd);
                if ((rd & msk) != exp) begin
                    if (bad == 0) begin first_rd = rd & msk; first_exp = exp; end
                    bad++;
                end
            end
        end
        check(bad == 0, req, first_rd, first_exp);
    endtask

    // table: count[19:8], expected window-full events[7:0]
    localparam logic [19:0] VEC [5] = '{20'h00500, 20'h04000, 20'h04601, 20'h08001, 20'h08302};

    task automatic run_xfer(input int cnt, input int exp_full, input bit first);
        int base = 0, fulls = 0;
        bit ok, done = 1'b0, stall_checked = !first;
        logic [31:0] st;
        reg_write(1, 32'h1C);
        reg_write(0, cmd_word(cnt, 3, 1'b1, 1'b0));
        while (!done) begin
            wait_irq(30000, ok);
            if (!ok) begin check(1'b0, "R5 irq timeout", 0, 1); break; end
            reg_read(2, st);
            if (st[4]) begin check(1'b0, "R6 unexpected error", st, 0); break; end
            if (st[3]) begin
                if (!stall_checked) begin
                    repeat (100) @(negedge clk);
                    check(scl_out == 1'b0, "R4 SCL held low in stall", 32'(scl_out), 0);
                    reg_read(2, st);
                    check(st[4:0] == 5'h08, "R4 no progress while stalled", st, 32'h08);
                    stall_checked = 1'b1;
                end
                check_window(base, 64, "R3 R4 full window contents");
                reg_write(2, 32'h08);
                reg_write(0, cmd_word(cnt, 3, 1'b1, 1'b1));
                base += 64; fulls++;
            end else if (st[2]) begin
                check_window(base, cnt - base, "R3 R5 final window contents");
                reg_write(2, 32'h04);
                reg_write(0, cmd_word(cnt, 3, 1'b0, 1'b0));
                done = 1'b1;
            end
        end
        check(done, "R5 transfer complete seen", 32'(done), 1);
        check(fulls == exp_full, "R4 R5 window-full count", fulls, exp_full);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] rd;
        bit ok;
        int hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(0, rd); check(rd == 0, "R1 command after reset", rd, 0);
        reg_read(1, rd); check(rd == 0, "R1 enable after reset", rd, 0);
        reg_read(2, rd); check(rd == 0, "R1 status after reset", rd, 0);
        reg_read(3, rd); check(rd == 124, "R1 divider after reset", rd, 124);
        check(irq == 0 && scl_out == 1 && sda_out == 1, "R1 outputs after reset",
              {29'b0, irq, scl_out, sda_out}, 32'h3);

        // R11 divider timing: SCL high phase = 2*(div+1)
        reg_write(3, 3);
        reg_write(1, 32'h04);
        reg_write(0, cmd_word(1, 3, 1'b1, 1'b0));
        @(posedge scl_out);
        hi = 0;
        @(negedge clk);
        while (scl_out) begin hi++; @(negedge clk); end
        check(hi == 8, "R11 SCL high length", hi, 8);
        wait_irq(30000, ok);
        reg_read(2, rd); check(rd == 32'h04, "R5 single byte done", rd, 32'h04);
        check_window(0, 1, "R3 single byte lane 0");
        reg_write(2, 32'h04);
        reg_write(0, 0);
        reg_write(3, 1);

        // table of transfer lengths (R2 R3 R4 R5)
        foreach (VEC[i]) run_xfer(int'(VEC[i][19:8]), int'(VEC[i][7:0]), i == 2);

        // R7 wrong type: error at once, no bus activity; R2 readback
        reg_write(1, 0);
        reg_write(0, cmd_word(9, 0, 1'b1, 1'b0));
        reg_read(2, rd); check(rd == 32'h10, "R7 wrong type error", rd, 32'h10);
        reg_read(0, rd); check(rd == 32'h00900001, "R2 command readback", rd, 32'h00900001);
        reg_write(0, cmd_word(9, 0, 1'b1, 1'b1));
        reg_read(0, rd); check(rd[1] == 1'b0, "R2 continue reads zero", rd, 32'h00900001);
        repeat (20) @(negedge clk);
        check(scl_out == 1 && sda_out == 1, "R7 no bus activity", {30'b0, scl_out, sda_out}, 3);

        // R7 zero count: done at once
        reg_write(0, cmd_word(0, 3, 1'b1, 1'b0));
        reg_read(2, rd); check(rd == 32'h14, "R7 zero count done", rd, 32'h14);
        check(scl_out == 1, "R7 zero count bus idle", 32'(scl_out), 1);

        // R9 masked interrupt
        check(irq == 0, "R9 irq masked by zero enable", 32'(irq), 0);
        reg_write(1, 32'h10);
        check(irq == 1, "R9 irq on enabled error", 32'(irq), 1);

        // R8 write-one-to-clear
        reg_write(2, 0);
        reg_read(2, rd); check(rd == 32'h14, "R8 write zero no effect", rd, 32'h14);
        reg_write(2, 32'h04);
        reg_read(2, rd); check(rd == 32'h10, "R8 clear one bit", rd, 32'h10);
        reg_write(2, 32'h10);
        reg_read(2, rd); check(rd == 0, "R8 clear last bit", rd, 0);
        check(irq == 0, "R9 irq drops after clear", 32'(irq), 0);

        // R10 hot-plug event
        @(negedge clk); hpd_evt = 1'b1; @(negedge clk); hpd_evt = 1'b0;
        reg_read(2, rd); check(rd == 32'h01, "R10 hot-plug status", rd, 1);
        check(irq == 0, "R9 hot-plug masked", 32'(irq), 0);
        reg_write(1, 32'h01);
        check(irq == 1, "R10 hot-plug irq", 32'(irq), 1);
        reg_write(2, 32'h01);
        reg_write(1, 0);

        // R6 sink does not acknowledge
        nack_addr = 1'b1;
        reg_write(1, 32'h14);
        reg_write(0, cmd_word(4, 3, 1'b1, 1'b0));
        wait_irq(30000, ok);
        check(ok, "R6 error irq", 32'(ok), 1);
        repeat (200) @(negedge clk);
        reg_read(2, rd); check(rd == 32'h10, "R6 error without done", rd, 32'h10);
        check(scl_out == 1 && sda_out == 1, "R6 bus released after STOP",
              {30'b0, scl_out, sda_out}, 3);
        nack_addr = 1'b0;
        reg_write(2, 32'h10);
        reg_write(0, 0);

        // R6 recovery: next transfer works
        run_xfer(3, 0, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule